// File: doc/BRIEF.md
# Multi-Width Shift and Rotate Unit

This block is the shift and rotate datapath of a small processor core. Each request supplies a 32-bit register value, an operand size (byte, word or longword), one of eight shift or rotate operations, a distance of one or two positions and the current carry flag. One clock later the block returns the new register value and the negative, zero, overflow and carry flags, together with a single-cycle valid strobe.

Only the low 8 or 16 bits take part in byte and word operations. The bits above the selected width are written back unchanged. Rotates through carry work at every width. At a distance of two, the carry acts as one extra bit in a ring that is one bit wider than the operand.

Top module: `shift_rotate_unit`

## Requirements
- R1: `size` selects the operand width: 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. For 8- and 16-bit sizes, the result bits above the selected width equal the operand bits.
- R2: Opcode 0 (arithmetic left) and opcode 2 (logical left) shift the selected width left and fill the low end with zeros. `flag_c` is the last bit shifted out.
- R3: Opcode 1 (arithmetic right) shifts right and copies the selected width's sign bit into the vacated positions. `flag_c` is the last bit shifted out.
- R4: Opcode 3 (logical right) shifts right and fills the vacated high positions with zeros. `flag_c` is the last bit shifted out.
- R5: Opcode 4 (rotate left) and opcode 5 (rotate right) rotate the selected width without using the carry. `flag_c` is the last bit that wrapped around.
- R6: Opcode 6 (rotate left through carry) and opcode 7 (rotate right through carry) rotate a ring made of the carry plus the selected width. `carry_in` enters the vacated end. For a distance of two, `flag_c` is the second bit moved out.
- R7: `two_pos` = 0 moves by one position and `two_pos` = 1 moves by two positions.
- R8: `flag_n` is the top bit of the selected width of the result. `flag_z` is set exactly when the selected width of the result is all zeros.
- R9: `flag_v` is set on an arithmetic left shift when any shifted-out bit, or the new sign bit, differs from the original sign bit. For every other opcode, `flag_v` is 0.
- R10: When `start` is high at a clock edge, the result and flags appear after that edge and `valid` is high for exactly that one cycle. When `start` is low, `valid` falls and the result and flags hold their values.
- R11: A synchronous reset with `rst_n` low clears `result`, all flags and `valid` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request strobe, one cycle per operation |
| operand | input | 32 | Register value to shift or rotate |
| size | input | 2 | Operand width code |
| op | input | 3 | Operation code |
| two_pos | input | 1 | 0 = one position, 1 = two positions |
| carry_in | input | 1 | Current carry flag |
| result | output | 32 | Registered new register value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| valid | output | 1 | One-cycle strobe marking a fresh result |

## Verification
The bench builds the unit with its default lane widths of 8, 16 and 32 bits. This exposes every size code, and through size code 3 the alias for the full width. It sweeps all eight opcodes at both distances and both carry values over operands chosen to set the sign bit, the bit below it and the low bits. This drives the carry-ring corner at distance two and the overflow cases where only the second shifted-out bit or only the new sign differs from the original sign. Hand-worked literal cases sit alongside the model comparisons, together with hold and reset checks.

// File: rtl/srt_pkg.sv
// Shared types of the shift and rotate unit.
// Assumes the opcode numbering below is the one the decoder emits.
package srt_pkg;
    typedef enum logic [2:0] {
        OP_SHAL  = 3'd0,
        OP_SHAR  = 3'd1,
        OP_SHLL  = 3'd2,
        OP_SHLR  = 3'd3,
        OP_ROTL  = 3'd4,
        OP_ROTR  = 3'd5,
        OP_ROTXL = 3'd6,
        OP_ROTXR = 3'd7
    } srt_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } srt_size_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } srt_flags_t;

    localparam int LANES = 3;
endpackage

// File: rtl/srt_step.sv
// One-position shift or rotate of a W-bit value.
// Combinational. Assumes W >= 3. cin is used only by the rotates through carry.
module srt_step
    import srt_pkg::*;
#(
    parameter int W = 8
) (
    input  srt_op_e        op,
    input  logic [W-1:0]   din,
    input  logic           cin,
    output logic [W-1:0]   dout,
    output logic           cout
);
    // Choose the value moving in and the bit moving out for this opcode.
    always_comb begin
        unique case (op)
            OP_SHAL, OP_SHLL: begin dout = {din[W-2:0], 1'b0};     cout = din[W-1]; end
            OP_SHAR:          begin dout = {din[W-1], din[W-1:1]}; cout = din[0];   end
            OP_SHLR:          begin dout = {1'b0, din[W-1:1]};     cout = din[0];   end
            OP_ROTL:          begin dout = {din[W-2:0], din[W-1]}; cout = din[W-1]; end
            OP_ROTR:          begin dout = {din[0], din[W-1:1]};   cout = din[0];   end
            OP_ROTXL:         begin dout = {din[W-2:0], cin};      cout = din[W-1]; end
            default:          begin dout = {cin, din[W-1:1]};      cout = din[0];   end
        endcase
    end
endmodule

// File: rtl/srt_lane.sv
// Width-specific lane. Chains MAX_STEPS single-position steps and derives flags.
// The carry out of each step feeds the next step, so a rotate through carry
// of two positions behaves as a ring one bit wider than W.
module srt_lane
    import srt_pkg::*;
#(
    parameter int W         = 8,
    parameter int MAX_STEPS = 2
) (
    input  srt_op_e        op,
    input  logic [W-1:0]   din,
    input  logic           cin,
    input  logic           two_pos,
    output logic [W-1:0]   dout,
    output srt_flags_t     flags
);
    logic [W-1:0] stage_d [MAX_STEPS+1];
    logic         stage_c [MAX_STEPS+1];
    logic [MAX_STEPS-1:0] sign_moved;

    assign stage_d[0] = din;
    assign stage_c[0] = cin;

    genvar s;
    generate
        for (s = 0; s < MAX_STEPS; s++) begin : g_step
            srt_step #(.W(W)) u_step (
                .op   (op),
                .din  (stage_d[s]),
                .cin  (stage_c[s]),
                .dout (stage_d[s+1]),
                .cout (stage_c[s+1])
            );
            // Record whether the sign after this step departs from the original sign.
            assign sign_moved[s] = stage_d[s+1][W-1] ^ din[W-1];
        end
    endgenerate

    // Pick the stage that matches the requested distance and form the flags.
    always_comb begin
        if (two_pos) begin
            dout    = stage_d[2];
            flags.c = stage_c[2];
        end else begin
            dout    = stage_d[1];
            flags.c = stage_c[1];
        end
        flags.n = dout[W-1];
        flags.z = (dout == '0);
        flags.v = (op == OP_SHAL) && (sign_moved[0] || (two_pos && sign_moved[1]));
    end
endmodule

// File: rtl/srt_merge.sv
// Selects the lane for the requested size and keeps the unselected upper bits.
// Assumes each lane result is zero-extended to LONG_W bits.
module srt_merge
    import srt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16,
    parameter int LONG_W = 32
) (
    input  srt_size_e                      size,
    input  logic [LONG_W-1:0]              operand,
    input  logic [LANES-1:0][LONG_W-1:0]   lane_res,
    input  srt_flags_t [LANES-1:0]         lane_flags,
    output logic [LONG_W-1:0]              res,
    output srt_flags_t                     flags
);
    localparam logic [LONG_W-1:0] BYTE_MASK = LONG_W'((64'd1 << BYTE_W) - 64'd1);
    localparam logic [LONG_W-1:0] WORD_MASK = LONG_W'((64'd1 << WORD_W) - 64'd1);

    logic [LONG_W-1:0] mask;
    int unsigned       sel;

    // Decode the size into a lane index and a mask for the lane bits.
    always_comb begin
        unique case (size)
            SZ_BYTE: begin sel = 0; mask = BYTE_MASK; end
            SZ_WORD: begin sel = 1; mask = WORD_MASK; end
            default: begin sel = 2; mask = '1;        end
        endcase
    end

    // Combine the lane bits with the operand bits above them.
    always_comb begin
        res   = (operand & ~mask) | (lane_res[sel] & mask);
        flags = lane_flags[sel];
    end
endmodule

// File: rtl/shift_rotate_unit.sv
// Shift and rotate datapath, top level.
// Three lanes evaluate byte, word and longword in parallel. The merge picks
// one lane, and the output register captures it on start.
// Assumes a synchronous active-low reset and a single-cycle start strobe.
module shift_rotate_unit
    import srt_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16,
    parameter int LONG_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LONG_W-1:0] operand,
    input  logic [1:0]        size,
    input  logic [2:0]        op,
    input  logic              two_pos,
    input  logic              carry_in,
    output logic [LONG_W-1:0] result,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_v,
    output logic              flag_c,
    output logic              valid
);
    logic [LANES-1:0][LONG_W-1:0] lane_res;
    srt_flags_t [LANES-1:0]       lane_flags;
    logic [LONG_W-1:0]            merged;
    srt_flags_t                   merged_flags;
    srt_op_e                      op_e;
    srt_flags_t                   flags_q;

    assign op_e = srt_op_e'(op);

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            localparam int LW = (g == 0) ? BYTE_W : (g == 1) ? WORD_W : LONG_W;
            logic [LW-1:0] lane_out;
            srt_lane #(.W(LW), .MAX_STEPS(2)) u_lane (
                .op      (op_e),
                .din     (operand[LW-1:0]),
                .cin     (carry_in),
                .two_pos (two_pos),
                .dout    (lane_out),
                .flags   (lane_flags[g])
            );
            assign lane_res[g] = LONG_W'(lane_out);
        end
    endgenerate

    srt_merge #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .LONG_W(LONG_W)) u_merge (
        .size       (srt_size_e'(size)),
        .operand    (operand),
        .lane_res   (lane_res),
        .lane_flags (lane_flags),
        .res        (merged),
        .flags      (merged_flags)
    );

    // Capture the result and flags on start, and raise valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result  <= '0;
            flags_q <= '0;
            valid   <= 1'b0;
        end else begin
            valid <= start;
            if (start) begin
                result  <= merged;
                flags_q <= merged_flags;
            end
        end
    end

    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_v = flags_q.v;
    assign flag_c = flags_q.c;
endmodule

// File: rtl/srt_checker.sv
// Properties of the shift and rotate unit, attached to the top level by bind.
module srt_checker #(
    parameter int LONG_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LONG_W-1:0] operand,
    input logic [1:0]        size,
    input logic [2:0]        op,
    input logic [LONG_W-1:0] result,
    input logic              flag_z,
    input logic              flag_v,
    input logic              valid
);
    // R10
    strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> valid);
    // R10
    strobe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !valid);
    // R10
    hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(result));
    // R1
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size == 2'd0) |=> result[LONG_W-1:8] == $past(operand[LONG_W-1:8]));
    // R1
    word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size == 2'd1) |=> result[LONG_W-1:16] == $past(operand[LONG_W-1:16]));
    // R8
    long_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && size[1]) |=> flag_z == (result == '0));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op != 3'd0) |=> !flag_v);
    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && op == 3'd3 && size[1]) |=> !result[LONG_W-1]);
endmodule

bind shift_rotate_unit srt_checker #(.LONG_W(LONG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .size    (size),
    .op      (op),
    .result  (result),
    .flag_z  (flag_z),
    .flag_v  (flag_v),
    .valid   (valid)
);

// File: tb/sim_shift_rotate_unit.sv
// Directed bench for the shift and rotate unit. A behavioural model is written
// from the requirements, and hand-worked literals check the model's corners.
module sim_shift_rotate_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic [1:0]  size = '0;
    logic [2:0]  op = '0;
    logic        two_pos = 1'b0;
    logic        carry_in = 1'b0;
    logic [31:0] result;
    logic        flag_n, flag_z, flag_v, flag_c, valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shift_rotate_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
        .size(size), .op(op), .two_pos(two_pos), .carry_in(carry_in),
        .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .valid(valid)
    );

    // Expected {result, n, z, v, c}.
    function automatic logic [35:0] model(logic [31:0] opnd, logic [1:0] sz,
                                          logic [2:0] opc, logic two, logic cin);
        int w, n;
        logic [63:0] mask, x, r, y, ring;
        logic c, v;
        w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        n = two ? 2 : 1;
        mask = (64'd1 << w) - 64'd1;
        x = {32'b0, opnd} & mask;
        v = 1'b0;
        r = '0;
        c = 1'b0;
        ring = (64'd1 << (w + 1)) - 64'd1;
        case (opc)
            3'd0, 3'd2: begin
                r = (x << n) & mask; c = x[w-n];
                if (opc == 3'd0) begin
                    y = x >> (w - n - 1);
                    v = (y != 0) && (y != ((64'd1 << (n + 1)) - 64'd1));
                end
            end
            3'd1: begin
                r = (x >> n) | (x[w-1] ? (mask & ~(mask >> n)) : 64'd0); c = x[n-1];
            end
            3'd3: begin r = x >> n; c = x[n-1]; end
            3'd4: begin r = ((x << n) | (x >> (w - n))) & mask; c = r[0]; end
            3'd5: begin r = ((x >> n) | (x << (w - n))) & mask; c = r[w-1]; end
            3'd6: begin
                y = x | ({63'b0, cin} << w);
                y = ((y << n) | (y >> (w + 1 - n))) & ring;
                r = y & mask; c = y[w];
            end
            default: begin
                y = x | ({63'b0, cin} << w);
                y = ((y >> n) | (y << (w + 1 - n))) & ring;
                r = y & mask; c = y[w];
            end
        endcase
        return {(opnd & ~mask[31:0]) | r[31:0], r[w-1], (r == 0), v, c};
    endfunction

    task automatic check(string tag, logic [35:0] got, logic [35:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    // Issue one request and check the registered response one edge later.
    task automatic run_op(string tag, logic [31:0] a, logic [1:0] sz, logic [2:0] o,
                          logic two, logic cin, logic [35:0] exp);
        @(negedge clk);
        operand = a; size = sz; op = o; two_pos = two; carry_in = cin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " valid"}, {35'd0, valid}, 36'd1);
        check(tag, {result, flag_n, flag_z, flag_v, flag_c}, exp);
    endtask

    task automatic t_reset;
        check("R11 reset state", {result, flag_n, flag_z, flag_v, flag_c}, 36'd0);
        check("R11 reset valid", {35'd0, valid}, 36'd0);
    endtask

    task automatic t_literals;
        // R6: byte ROTXL x2 of 0x81 with carry 0 gives 0x05, carry 0
        run_op("R6 rotx left byte", 32'h1234_5681, 2'd0, 3'd6, 1'b1, 1'b0,
               {32'h1234_5605, 4'b0000});
        // R3: word SHAR x2 of 0x8001 gives 0xE000, negative
        run_op("R3 sign fill word", 32'hFFFF_8001, 2'd1, 3'd1, 1'b1, 1'b0,
               {32'hFFFF_E000, 4'b1000});
        // R9: long SHAL x2 of 0x40000000: zero, overflow, carry
        run_op("R9 overflow long", 32'h4000_0000, 2'd2, 3'd0, 1'b1, 1'b0,
               {32'h0000_0000, 4'b0111});
        // R4: long SHLR x1 of 0x80000001 clears the top bit and carries out 1
        run_op("R4 zero fill long", 32'h8000_0001, 2'd3, 3'd3, 1'b0, 1'b1,
               {32'h4000_0000, 4'b0001});
        // R5: word ROTR x1 of 0x0001 with carry_in 0 wraps the low bit to the top
        run_op("R5 rotate word", 32'hAAAA_0001, 2'd1, 3'd5, 1'b0, 1'b0,
               {32'hAAAA_8000, 4'b1001});
    endtask

    task automatic t_sweep;
        logic [31:0] pats [6] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_8080,
                                  32'h4000_4040, 32'h1234_56C1, 32'hA5C3_3C5A};
        for (int p = 0; p < 6; p++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 8; o++)
                    for (int t = 0; t < 2; t++)
                        for (int c = 0; c < 2; c++) begin
                            // R1 R2 R3 R4 R5 R6 R7 R8 R9
                            run_op("R7 sweep", pats[p], 2'(s), 3'(o), 1'(t), 1'(c),
                                   model(pats[p], 2'(s), 3'(o), 1'(t), 1'(c)));
                        end
    endtask

    task automatic t_hold;
        logic [35:0] snap;
        run_op("R10 issue", 32'h0000_00F0, 2'd0, 3'd2, 1'b0, 1'b0,
               model(32'h0000_00F0, 2'd0, 3'd2, 1'b0, 1'b0));
        snap = {result, flag_n, flag_z, flag_v, flag_c};
        operand = 32'hDEAD_BEEF; op = 3'd7;
        repeat (3) @(negedge clk);
        check("R10 hold", {result, flag_n, flag_z, flag_v, flag_c}, snap);
        check("R10 valid low", {35'd0, valid}, 36'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_literals();
        t_hold();
        t_sweep();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule